// File: doc/BRIEF.md
# Packet Deframer with Sync Detect

This block sits behind a demodulator and clock-recovery stage. It takes one recovered bit per `bit_stb` strobe, most significant bit first. While idle it hunts for a run of alternating bits and reports it. Once that run has been seen, it compares a sliding 16-bit window against the programmed sync pattern, which is usually 0x2DD4. An exact match opens a frame.

The first byte of the frame is a payload length. The block then stores that many payload bytes into a 64-byte receive queue and takes a 16-bit check value from the line. A frame whose check value agrees is committed to the queue and becomes readable. A frame that disagrees is dropped by rewinding the write pointer. A frame with an illegal length, or one that would not fit in the queue, is abandoned the same way.

Each outcome leaves as a one-cycle event pulse, ready to feed an interrupt controller. The last accepted length is held on `rx_len`. A consumer pops committed bytes with `rd_en`.

Top module: `pkt_deframer`

## Requirements
- R1: `ev_preamble` pulses for one cycle when, while hunting, 16 consecutive strobed bits have alternated in value. It pulses only once per unbroken run, and a run of 14 alternating bits raises no event.
- R2: `ev_sync` pulses for one cycle only when the last 16 strobed bits equal `sync_word` exactly, oldest bit as the MSB, and an alternating run (R1) has been seen since the last frame ended. A window differing in one bit raises nothing.
- R3: The 8 bits after the sync pattern form the length byte, MSB first. An accepted length appears on `rx_len` and stays there until the next accepted length.
- R4: A length byte of 0 or above 64 ends the frame at once. No byte is stored, no outcome event is raised and `rx_len` keeps its old value.
- R5: The check value is CRC-16 with polynomial 0x1021 and start value 0xFFFF, shifted MSB first with no final inversion. It covers the length byte and the payload. The 16 received check bits follow the payload, MSB first. On a match `ev_pkt_ok` pulses and the payload bytes become readable in arrival order.
- R6: On a check-value mismatch `ev_crc_err` pulses and none of that frame's bytes can ever be read. Bytes committed earlier are untouched.
- R7: The queue holds 64 bytes. `fifo_empty` is high when no committed byte is waiting. `rd_data` shows the oldest committed byte, and `rd_en` while not empty removes it.
- R8: A payload byte that arrives while the queue is full pulses `ev_overflow`. The whole frame is discarded and the block returns to hunting; earlier committed bytes remain.
- R9: `ev_pkt_ok`, `ev_crc_err` and `ev_overflow` never pulse in the same cycle, and a frame raises at most one of them.
- R10: Only cycles with `bit_stb` high advance the block. `bit_in` in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Recovered data bit |
| bit_stb | input | 1 | Marks the cycle in which `bit_in` is valid |
| sync_word | input | 16 | Sync pattern to match |
| rd_en | input | 1 | Pop oldest committed byte |
| rd_data | output | 8 | Oldest committed byte |
| fifo_empty | output | 1 | No committed byte waiting |
| rx_len | output | 8 | Last accepted payload length |
| ev_preamble | output | 1 | Alternating run found (pulse) |
| ev_sync | output | 1 | Sync pattern matched (pulse) |
| ev_pkt_ok | output | 1 | Frame committed (pulse) |
| ev_crc_err | output | 1 | Frame dropped on check mismatch (pulse) |
| ev_overflow | output | 1 | Frame dropped on full queue (pulse) |

## Verification
The assertions assume that `bit_stb` is a single-cycle strobe and that `sync_word` is held constant while a frame is in flight. They also assume `rd_en` is raised only between frames. The stimulus keeps to these assumptions: bits are sent with random idle gaps in which `bit_in` is scrambled, the sync pattern changes only between frames, and the queue is drained only after a frame has finished. Random payload bytes always have two adjacent bits cleared, so that leftover payload bits after an aborted frame cannot form a false alternating run.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;

   typedef enum logic [1:0] {
      ST_HUNT,
      ST_LEN,
      ST_BODY,
      ST_CHECK
   } dfr_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/deframer_preamble.sv
module deframer_preamble #(
   parameter int unsigned RUN_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic stb,
   input  logic bit_in,
   output logic found
);
   localparam int unsigned CW = $clog2(RUN_BITS + 1);
   localparam logic [CW-1:0] RUN_MAX = CW'(RUN_BITS);

   if (RUN_BITS < 2) begin : g_chk_run
      $error("RUN_BITS must be at least 2");
   end

   logic [CW-1:0] run;
   logic          last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= '0;
         last  <= 1'b0;
         found <= 1'b0;
      end else begin
         found <= 1'b0;
         if (!en) begin
            run <= '0;
         end else if (stb) begin
            last <= bit_in;
            if (run == '0 || bit_in != last) begin
               if (run != RUN_MAX) begin
                  run <= run + 1'b1;
                  if (run == RUN_MAX - 1'b1) found <= 1'b1;
               end
            end else begin
               run <= CW'(1);
            end
         end
      end
   end

   // R1: a single pulse per run
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      found |=> !found);
   // R1: a pulse only follows a strobed bit while enabled
   a_r1_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> $past(en && stb));

endmodule

// File: rtl/deframer_crc.sv
module deframer_crc #(
   parameter int unsigned    W    = 16,
   parameter logic [W-1:0]   POLY = 16'h1021,
   parameter logic [W-1:0]   INIT = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         shift,
   input  logic         bit_in,
   output logic [W-1:0] crc
);
   if (W < 2) begin : g_chk_w
      $error("CRC width must be at least 2");
   end

   logic [W-1:0] next;
   always_comb begin
      next = {crc[W-2:0], 1'b0};
      if (crc[W-1] ^ bit_in) next = next ^ POLY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     crc <= INIT;
      else if (init)  crc <= INIT;
      else if (shift) crc <= next;
   end

   // R5: register holds its value between strobes
   a_r5_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !shift) |=> $stable(crc));

endmodule

// File: rtl/deframer_fifo.sv
module deframer_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         commit,
   input  logic         rollback,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr;
   logic [PW-1:0] used;

   assign used  = wr_ptr - rd_ptr;
   assign full  = (used == DEPTH_P);
   assign empty = (cmt_ptr == rd_ptr);
   assign rdata = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr && !full) mem[wr_ptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         cmt_ptr <= '0;
         rd_ptr  <= '0;
      end else begin
         if (rollback)         wr_ptr  <= cmt_ptr;
         else if (wr && !full) wr_ptr  <= wr_ptr + 1'b1;
         if (commit)           cmt_ptr <= wr_ptr;
         if (rd && !empty)     rd_ptr  <= rd_ptr + 1'b1;
      end
   end

   // R7: occupancy never exceeds the depth
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      used <= DEPTH_P);
   // R7: committed region lies inside the written region
   a_r7_commit_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_ptr - rd_ptr) <= used);
   // R6: a rollback rewinds the write pointer to the commit point
   a_r6_rollback: assert property (@(posedge clk) disable iff (!rst_n)
      rollback |=> (wr_ptr == $past(cmt_ptr)));

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
   import pkt_deframer_pkg::*;
#(
   parameter int unsigned SYNC_W           = 16,
   parameter int unsigned PRE_BITS         = 16,
   parameter int unsigned MAX_LEN          = 64,
   parameter int unsigned FIFO_DEPTH       = 64,
   parameter bit          REQUIRE_PREAMBLE = 1'b1,
   parameter logic [15:0] CRC_POLY         = 16'h1021,
   parameter logic [15:0] CRC_INIT         = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic              bit_stb,
   input  logic [SYNC_W-1:0] sync_word,
   input  logic              rd_en,
   output logic [7:0]        rd_data,
   output logic              fifo_empty,
   output logic [7:0]        rx_len,
   output logic              ev_preamble,
   output logic              ev_sync,
   output logic              ev_pkt_ok,
   output logic              ev_crc_err,
   output logic              ev_overflow
);
   localparam int unsigned CRC_W = 16;
   localparam int unsigned CCW   = $clog2(CRC_W);
   localparam logic [7:0]  LEN_MAX = 8'(MAX_LEN);

   if (SYNC_W < 2) begin : g_chk_sync
      $error("SYNC_W must be at least 2");
   end
   if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_chk_len
      $error("MAX_LEN must lie in 1..255");
   end

   dfr_state_e         state;
   logic               pre_seen, sync_gate, sync_hit;
   logic [SYNC_W-2:0]  sync_sh;
   logic [2:0]         bcnt;
   logic [BYTE_W-2:0]  byte_sh;
   logic [7:0]         new_byte, remain;
   logic [CCW-1:0]     ccnt;
   logic [CRC_W-2:0]   crc_rx;
   logic [CRC_W-1:0]   crc_calc;
   logic               byte_done, fifo_wr, fifo_full, ovf_now;
   logic               chk_last, chk_match, commit, rollback;

   // Variant: sync may or may not require a prior alternating run
   if (REQUIRE_PREAMBLE) begin : g_gate_pre
      assign sync_gate = pre_seen;
   end else begin : g_gate_free
      assign sync_gate = 1'b1;
   end

   assign sync_hit  = ({sync_sh, bit_in} == sync_word);
   assign byte_done = bit_stb && (bcnt == 3'd7);
   assign new_byte  = {byte_sh, bit_in};
   assign fifo_wr   = byte_done && (state == ST_BODY);
   assign ovf_now   = fifo_wr && fifo_full;
   assign chk_last  = bit_stb && (state == ST_CHECK) && (ccnt == CCW'(CRC_W - 1));
   assign chk_match = ({crc_rx, bit_in} == crc_calc);
   assign commit    = chk_last && chk_match;
   assign rollback  = (chk_last && !chk_match) || ovf_now;

   deframer_preamble #(.RUN_BITS(PRE_BITS)) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (state == ST_HUNT),
      .stb    (bit_stb),
      .bit_in (bit_in),
      .found  (ev_preamble)
   );

   deframer_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (state == ST_HUNT),
      .shift  (bit_stb && (state == ST_LEN || state == ST_BODY)),
      .bit_in (bit_in),
      .crc    (crc_calc)
   );

   deframer_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) i_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (fifo_wr),
      .wdata    (new_byte),
      .commit   (commit),
      .rollback (rollback),
      .rd       (rd_en),
      .rdata    (rd_data),
      .empty    (fifo_empty),
      .full     (fifo_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_HUNT;
         pre_seen    <= 1'b0;
         sync_sh     <= '0;
         bcnt        <= '0;
         byte_sh     <= '0;
         remain      <= '0;
         ccnt        <= '0;
         crc_rx      <= '0;
         rx_len      <= '0;
         ev_sync     <= 1'b0;
         ev_pkt_ok   <= 1'b0;
         ev_crc_err  <= 1'b0;
         ev_overflow <= 1'b0;
      end else begin
         ev_sync     <= 1'b0;
         ev_pkt_ok   <= 1'b0;
         ev_crc_err  <= 1'b0;
         ev_overflow <= 1'b0;
         if (bit_stb) begin
            sync_sh <= {sync_sh[SYNC_W-3:0], bit_in};
            byte_sh <= new_byte[BYTE_W-2:0];
            if (state == ST_LEN || state == ST_BODY) bcnt <= bcnt + 1'b1;
         end
         unique case (state)
            ST_HUNT: begin
               if (ev_preamble) pre_seen <= 1'b1;
               if (bit_stb && sync_hit && sync_gate) begin
                  state    <= ST_LEN;
                  bcnt     <= '0;
                  pre_seen <= 1'b0;
                  ev_sync  <= 1'b1;
               end
            end
            ST_LEN: begin
               if (byte_done) begin
                  if (new_byte == 8'd0 || new_byte > LEN_MAX) begin
                     state <= ST_HUNT;
                  end else begin
                     rx_len <= new_byte;
                     remain <= new_byte;
                     state  <= ST_BODY;
                  end
               end
            end
            ST_BODY: begin
               if (byte_done) begin
                  if (fifo_full) begin
                     ev_overflow <= 1'b1;
                     state       <= ST_HUNT;
                  end else if (remain == 8'd1) begin
                     state <= ST_CHECK;
                     ccnt  <= '0;
                  end else begin
                     remain <= remain - 1'b1;
                  end
               end
            end
            ST_CHECK: begin
               if (bit_stb) begin
                  crc_rx <= {crc_rx[CRC_W-3:0], bit_in};
                  ccnt   <= ccnt + 1'b1;
                  if (chk_last) begin
                     state <= ST_HUNT;
                     if (chk_match) ev_pkt_ok  <= 1'b1;
                     else           ev_crc_err <= 1'b1;
                  end
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   // R9: at most one outcome per cycle
   a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_pkt_ok, ev_crc_err, ev_overflow}));
   // R2: sync event is a single-cycle pulse
   a_r2_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sync |=> !ev_sync);
   // R2: capture opens only together with a sync event
   a_r2_capture_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LEN && $past(state) == ST_HUNT) |-> ev_sync);
   // R10: no progress without a strobe
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(state));
   // R4: payload capture runs only with a legal length
   a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BODY) |-> (rx_len != 8'd0 && rx_len <= LEN_MAX));

endmodule

// File: tb/test_pkt_deframer.sv
module test_pkt_deframer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_in = 1'b0;
   logic        bit_stb = 1'b0;
   logic [15:0] sync_word = 16'h2DD4;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data, rx_len;
   logic        fifo_empty, ev_preamble, ev_sync, ev_pkt_ok, ev_crc_err, ev_overflow;

   int n_chk = 0, n_fail = 0;
   int c_pre = 0, c_sync = 0, c_ok = 0, c_err = 0, c_ovf = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [7:0] model_q[$];
   logic [7:0] last_len = 8'd0;

   always #2.5 clk = ~clk;

   pkt_deframer i_pkt_deframer (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
      .sync_word(sync_word), .rd_en(rd_en), .rd_data(rd_data),
      .fifo_empty(fifo_empty), .rx_len(rx_len), .ev_preamble(ev_preamble),
      .ev_sync(ev_sync), .ev_pkt_ok(ev_pkt_ok), .ev_crc_err(ev_crc_err),
      .ev_overflow(ev_overflow)
   );

   always @(negedge clk) if (rst_n) begin
      if (ev_preamble) c_pre++;
      if (ev_sync)     c_sync++;
      if (ev_pkt_ok)   c_ok++;
      if (ev_crc_err)  c_err++;
      if (ev_overflow) c_ovf++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_of(input logic [7:0] b[$]);
      logic [15:0] c = 16'hFFFF;
      foreach (b[i]) for (int k = 7; k >= 0; k--) begin
         logic fb = c[15] ^ b[i][k];
         c = {c[14:0], 1'b0};
         if (fb) c = c ^ 16'h1021;
      end
      return c;
   endfunction

   task automatic send_bit(input logic b);
      int gap;
      @(negedge clk);
      bit_in = b; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
         bit_in = 1'($urandom);  // R10: ignored without strobe
         @(negedge clk);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int k = 7; k >= 0; k--) send_bit(b[k]);
   endtask

   task automatic run_pkt(input int pre, input logic [15:0] sw, input int len,
                          input bit bad, input string tag);
      logic [7:0] body[$];
      logic [15:0] c;
      int p0, s0, o0, e0, v0;
      bit syn, legal, ovf;
      p0 = c_pre; s0 = c_sync; o0 = c_ok; e0 = c_err; v0 = c_ovf;
      syn   = (pre >= 16) && (sw == sync_word);
      legal = (len >= 1) && (len <= 64);
      for (int i = 0; i < pre; i++) send_bit(i[0] ? 1'b0 : 1'b1);
      for (int k = 15; k >= 0; k--) send_bit(sw[k]);
      if (syn) begin
         send_byte(8'(len));
         if (legal) begin
            body.push_back(8'(len));
            for (int i = 0; i < len; i++) begin
               logic [7:0] b = 8'($urandom);
               b[3:2] = 2'b00;
               body.push_back(b);
               send_byte(b);
            end
            c = crc_of(body);
            if (bad) c = c ^ 16'h0001;
            send_byte(c[15:8]);
            send_byte(c[7:0]);
         end
      end
      repeat (4) @(negedge clk);
      ovf = syn && legal && (model_q.size() + len > 64);
      chk((c_pre - p0) == ((pre >= 16) ? 1 : 0), {"R1 preamble ", tag}, c_pre - p0, (pre >= 16) ? 1 : 0);
      chk((c_sync - s0) == (syn ? 1 : 0), {"R2 sync ", tag}, c_sync - s0, syn ? 1 : 0);
      chk((c_ovf - v0) == (ovf ? 1 : 0), {"R8 overflow ", tag}, c_ovf - v0, ovf ? 1 : 0);
      chk((c_ok - o0) == ((syn && legal && !ovf && !bad) ? 1 : 0), {"R5 ok ", tag},
          c_ok - o0, (syn && legal && !ovf && !bad) ? 1 : 0);
      chk((c_err - e0) == ((syn && legal && !ovf && bad) ? 1 : 0), {"R6 crc_err ", tag},
          c_err - e0, (syn && legal && !ovf && bad) ? 1 : 0);
      if (syn && legal) last_len = 8'(len);
      chk(rx_len == last_len, {"R3 R4 rx_len ", tag}, rx_len, last_len);
      if (syn && legal && !ovf && !bad)
         for (int i = 1; i < body.size(); i++) model_q.push_back(body[i]);
   endtask

   task automatic drain(input string tag);
      int n = 0;
      while (!fifo_empty && n < 80) begin
         logic [7:0] e = (model_q.size() > 0) ? model_q.pop_front() : 8'hXX;
         chk(rd_data === e, {"R7 data ", tag}, rd_data, e);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
         n++;
      end
      chk(model_q.size() == 0, {"R6 R7 leftover ", tag}, model_q.size(), 0);
      model_q.delete();
   endtask

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fifo_empty == 1'b1, "R7 reset empty", fifo_empty, 1);
      chk(rx_len == 8'd0, "R3 reset rx_len", rx_len, 0);
      chk({ev_preamble, ev_sync, ev_pkt_ok, ev_crc_err, ev_overflow} == 5'b0,
          "R9 reset events", {ev_preamble, ev_sync, ev_pkt_ok, ev_crc_err, ev_overflow}, 0);

      run_pkt(16, 16'h2DD4, 5, 1'b0, "good5");          // R5
      drain("good5");
      run_pkt(24, 16'h2DD4, 8, 1'b1, "bad8");           // R6
      run_pkt(16, 16'h2DD4, 3, 1'b0, "good3");
      drain("after bad");
      run_pkt(16, 16'h2DD4, 0, 1'b0, "len0");           // R4
      run_pkt(16, 16'h2DD4, 70, 1'b0, "len70");         // R4
      run_pkt(14, 16'h2DD4, 4, 1'b0, "short pre");      // R1
      run_pkt(20, 16'h2CD4, 4, 1'b0, "wrong sync");     // R2
      sync_word = 16'h3C5A;
      run_pkt(16, 16'h3C5A, 64, 1'b0, "max len");       // R3 R5
      drain("max len");
      run_pkt(16, 16'h3C5A, 40, 1'b0, "fill");          // R8
      run_pkt(16, 16'h3C5A, 40, 1'b0, "overflow");      // R8
      drain("overflow");
      sync_word = 16'h2DD4;
      for (int i = 0; i < 25; i++) begin
         int len = $urandom_range(1, 64);
         run_pkt(16 + $urandom_range(0, 8), 16'h2DD4, len, ($urandom_range(0, 3) == 0), "random");
         if ($urandom_range(0, 1) == 1) drain("random");
      end
      drain("final");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule